// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the seven-cycle entry into an interrupt or break handler for a small 8-bit processor core. At each instruction boundary it polls for work: a pending NMI, which is latched from a falling edge of the active-low line, an unmasked IRQ level, or a decoded BRK opcode. When one of these is present it takes over the bus. It first makes two idle reads at the return address. It then pushes the return address high byte, the return address low byte and the status byte onto the stack page. Finally it reads the two-byte handler vector, loads the new PC and stack pointer, and raises the interrupt-disable flag.

The core's decoder supplies the boundary and BRK-decode signals and the live PC, status and stack pointer. The core applies the load strobes this block returns. An NMI can arrive while a BRK or IRQ entry is already under way. If it arrives early enough, it takes over that entry's vector fetch and the status byte already pushed is left unchanged. If it arrives late, it waits for the next boundary, so one handler instruction runs first.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry occupies exactly seven enabled cycles (steps 0 to 6) with `seqActive` high. Steps 0 and 1 drive `busAddr` with the return address and do not write.
- R2: Steps 2, 3 and 4 each write once to address 0x0100 + stack pointer, starting at `spIn` captured at the poll, and the pointer drops by one after each write. Step 6 raises `spLoad` with `spOut` equal to the captured value minus 3.
- R3: Step 2 writes the high byte and step 3 the low byte of the return address. For BRK the return address is `pcIn` + 2, and for IRQ and NMI it is `pcIn`, both captured at the poll.
- R4: Step 4 writes the captured `pIn` with bit 5 forced to 1 and bit 4 set for a BRK entry and cleared for IRQ or NMI.
- R5: Step 5 reads the vector low byte at 0xFFFA (NMI) or 0xFFFE (IRQ/BRK) and pulses `setIFlag`. Step 6 reads the address one higher and pulses `pcLoad` with `pcOut` = {byte read in step 6, byte read in step 5}.
- R6: A falling edge of `nmiN` seen on an enabled cycle is held until an entry uses the NMI vector. An entry starts only at an enabled cycle with `instrBoundary` high while idle. The priority is pending NMI, then `irqN` low with `pIn` bit 2 clear, then `brkDecode`.
- R7: If `nmiN` falls during steps 0 to 4 of a BRK or IRQ entry, steps 5 and 6 use the NMI vector, the pushed status keeps its BRK/IRQ form, and the NMI counts as serviced.
- R8: If `nmiN` falls during step 5 or 6 of a BRK or IRQ entry, that entry uses its own vector. The NMI stays pending and is taken at the next poll.
- R9: A BRK whose entry was taken over by an NMI leaves nothing behind: a later poll with no request starts no entry.
- R10: After an IRQ entry is taken over, a poll with `irqN` still low and `pIn` bit 2 clear starts an IRQ entry. With bit 2 set, or with `irqN` high, the poll starts nothing.
- R11: With `cycleEn` low the step does not advance and `busWrite`, `pcLoad` and `setIFlag` stay low.
- R12: `instrBoundary` has no effect while an entry is running, so the entry still lasts seven steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleEn | input | 1 | CPU cycle enable; low stalls the block |
| instrBoundary | input | 1 | Current cycle ends an instruction; poll point |
| brkDecode | input | 1 | Instruction at this boundary is BRK |
| pcIn | input | 16 | Current program counter |
| pIn | input | 8 | Current status byte |
| spIn | input | 8 | Current stack pointer |
| nmiN | input | 1 | NMI line, active low, edge-triggered |
| irqN | input | 1 | IRQ line, active low, level-sensitive |
| busRData | input | 8 | Read data from memory |
| busAddr | output | 16 | Bus address |
| busWData | output | 8 | Write data |
| busWrite | output | 1 | Write strobe |
| seqActive | output | 1 | Entry sequence running |
| pcOut | output | 16 | New program counter |
| pcLoad | output | 1 | Load `pcOut` |
| spOut | output | 8 | New stack pointer |
| spLoad | output | 1 | Load `spOut` |
| setIFlag | output | 1 | Set the interrupt-disable flag |

## Verification
The case that is hardest to reach from the ports is an NMI edge that lands on one particular step of an entry that is already running. The step at which the edge lands decides between a takeover and a deferral. The bench has one sequence-runner task that lowers `nmiN` at the start of a chosen step. It uses this to land the edge on steps 0 and 4, which must take over the vector, and on steps 5 and 6, which must defer. After a takeover or deferral it issues further polls to confirm that the NMI was serviced exactly once, that the BRK is gone and that the IRQ level comes back.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int STEP_W = 3;
  typedef logic [STEP_W-1:0] step_t;

  localparam step_t STEP_PUSH_HI = 3'd2;
  localparam step_t STEP_PUSH_LO = 3'd3;
  localparam step_t STEP_PUSH_P  = 3'd4;
  localparam step_t STEP_VEC_LO  = 3'd5;
  localparam step_t STEP_VEC_HI  = 3'd6;

  localparam int I_BIT = 2;
  localparam int B_BIT = 4;
  localparam int U_BIT = 5;

  typedef enum logic [1:0] {KIND_BRK, KIND_IRQ, KIND_NMI} kind_e;

  typedef struct packed {
    logic latchStart;
    logic startBrk;
    logic seqOn;
    logic pushHi;
    logic pushLo;
    logic pushP;
    logic vecLo;
    logic vecHi;
    logic vecNmi;
  } ctrl_strobes_t;
endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cycleEn,
  input  logic          instrBoundary,
  input  logic          brkDecode,
  input  logic          iFlag,
  input  logic          nmiN,
  input  logic          irqN,
  output ctrl_strobes_t strobes,
  output logic          seqActive
);
  logic  active;
  step_t step;
  kind_e kind;
  logic  nmiPrev, nmiPend, vecNmiQ;

  logic  irqOk, startReq, pollNow, nmiEdge, useNmiNow, nmiServe;
  kind_e pickKind;

  always_comb begin
    irqOk     = !irqN && !iFlag;
    startReq  = nmiPend || irqOk || brkDecode;
    pollNow   = !active && instrBoundary && startReq;
    if (nmiPend)    pickKind = KIND_NMI;
    else if (irqOk) pickKind = KIND_IRQ;
    else            pickKind = KIND_BRK;
    nmiEdge   = nmiPrev && !nmiN;
    // vector choice: own NMI entry, or an NMI latched before step 5 (takeover)
    useNmiNow = (kind == KIND_NMI) || nmiPend;
    nmiServe  = active && (step == STEP_VEC_LO) && useNmiNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      step    <= '0;
      kind    <= KIND_IRQ;
      nmiPrev <= 1'b1;
      nmiPend <= 1'b0;
      vecNmiQ <= 1'b0;
    end else if (cycleEn) begin
      nmiPrev <= nmiN;
      nmiPend <= nmiEdge || (nmiPend && !nmiServe);
      if (pollNow) begin
        active <= 1'b1;
        step   <= '0;
        kind   <= pickKind;
      end else if (active) begin
        if (step == STEP_VEC_LO) vecNmiQ <= useNmiNow;
        if (step == STEP_VEC_HI) begin
          active <= 1'b0;
          step   <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.latchStart = pollNow;
    strobes.startBrk   = (pickKind == KIND_BRK);
    strobes.seqOn      = active;
    strobes.pushHi     = active && (step == STEP_PUSH_HI);
    strobes.pushLo     = active && (step == STEP_PUSH_LO);
    strobes.pushP      = active && (step == STEP_PUSH_P);
    strobes.vecLo      = active && (step == STEP_VEC_LO);
    strobes.vecHi      = active && (step == STEP_VEC_HI);
    strobes.vecNmi     = (step == STEP_VEC_LO) ? useNmiNow : vecNmiQ;
  end

  assign seqActive = active;
endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] BRK_SKIP   = 16'd2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cycleEn,
  input  ctrl_strobes_t strobes,
  input  logic [15:0]   pcIn,
  input  logic [7:0]    pIn,
  input  logic [7:0]    spIn,
  input  logic [7:0]    busRData,
  output logic [15:0]   busAddr,
  output logic [7:0]    busWData,
  output logic          busWrite,
  output logic [15:0]   pcOut,
  output logic          pcLoad,
  output logic [7:0]    spOut,
  output logic          spLoad,
  output logic          setIFlag
);
  logic [15:0] retPc;
  logic [7:0]  pSave, spWork, vecLoQ, pFrame;
  logic [15:0] vecBase;
  logic        pushAny;

  always_comb begin
    pFrame        = pIn;
    pFrame[U_BIT] = 1'b1;
    pFrame[B_BIT] = strobes.startBrk;
    pushAny       = strobes.pushHi || strobes.pushLo || strobes.pushP;
    vecBase       = strobes.vecNmi ? VEC_NMI : VEC_IRQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retPc  <= '0;
      pSave  <= '0;
      spWork <= '0;
      vecLoQ <= '0;
    end else if (cycleEn) begin
      if (strobes.latchStart) begin
        retPc  <= strobes.startBrk ? pcIn + BRK_SKIP : pcIn;
        pSave  <= pFrame;
        spWork <= spIn;
      end else if (pushAny) begin
        spWork <= spWork - 8'd1;
      end
      if (strobes.vecLo) vecLoQ <= busRData;
    end
  end

  always_comb begin
    busAddr  = '0;
    busWData = '0;
    if (pushAny)             busAddr = {STACK_PAGE, spWork};
    else if (strobes.vecLo)  busAddr = vecBase;
    else if (strobes.vecHi)  busAddr = vecBase + 16'd1;
    else if (strobes.seqOn)  busAddr = retPc;
    if (strobes.pushHi)      busWData = retPc[15:8];
    else if (strobes.pushLo) busWData = retPc[7:0];
    else if (strobes.pushP)  busWData = pSave;
  end

  assign busWrite = cycleEn && pushAny;
  assign pcOut    = {busRData, vecLoQ};
  assign pcLoad   = cycleEn && strobes.vecHi;
  assign spOut    = spWork;
  assign spLoad   = cycleEn && strobes.vecHi;
  assign setIFlag = cycleEn && strobes.vecLo;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] BRK_SKIP   = 16'd2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cycleEn,
  input  logic        instrBoundary,
  input  logic        brkDecode,
  input  logic [15:0] pcIn,
  input  logic [7:0]  pIn,
  input  logic [7:0]  spIn,
  input  logic        nmiN,
  input  logic        irqN,
  input  logic [7:0]  busRData,
  output logic [15:0] busAddr,
  output logic [7:0]  busWData,
  output logic        busWrite,
  output logic        seqActive,
  output logic [15:0] pcOut,
  output logic        pcLoad,
  output logic [7:0]  spOut,
  output logic        spLoad,
  output logic        setIFlag
);
  ctrl_strobes_t strobes;

  irq_entry_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .instrBoundary(instrBoundary),
    .brkDecode(brkDecode), .iFlag(pIn[I_BIT]), .nmiN(nmiN), .irqN(irqN),
    .strobes(strobes), .seqActive(seqActive)
  );

  irq_entry_dp #(
    .VEC_NMI(VEC_NMI), .VEC_IRQ(VEC_IRQ), .STACK_PAGE(STACK_PAGE), .BRK_SKIP(BRK_SKIP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .strobes(strobes),
    .pcIn(pcIn), .pIn(pIn), .spIn(spIn), .busRData(busRData),
    .busAddr(busAddr), .busWData(busWData), .busWrite(busWrite),
    .pcOut(pcOut), .pcLoad(pcLoad), .spOut(spOut), .spLoad(spLoad),
    .setIFlag(setIFlag)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
  parameter logic [7:0]  STACK_PAGE = 8'h01
) (
  input logic        clk,
  input logic        rstN,
  input logic        cycleEn,
  input logic        seqActive,
  input logic [15:0] busAddr,
  input logic        busWrite,
  input logic        pcLoad,
  input logic        spLoad,
  input logic        setIFlag
);
  logic [3:0] enCnt;

  always_ff @(posedge clk) begin
    if (!rstN)            enCnt <= '0;
    else if (!seqActive)  enCnt <= '0;
    else if (cycleEn)     enCnt <= enCnt + 4'd1;
  end

  p_seven_steps_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(seqActive) |-> enCnt == 4'd7);

  p_push_page_r2: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> (seqActive && busAddr[15:8] == STACK_PAGE));

  p_vec_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    setIFlag |-> (busAddr == VEC_NMI || busAddr == VEC_IRQ) && !busWrite);

  p_vec_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |-> (busAddr == VEC_NMI + 16'd1 || busAddr == VEC_IRQ + 16'd1) && spLoad);

  p_stall_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !cycleEn |-> (!busWrite && !pcLoad && !setIFlag));
endmodule

bind irq_entry_seq irq_entry_chk #(
  .VEC_NMI(VEC_NMI), .VEC_IRQ(VEC_IRQ), .STACK_PAGE(STACK_PAGE)
) u_chk (
  .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .seqActive(seqActive),
  .busAddr(busAddr), .busWrite(busWrite), .pcLoad(pcLoad), .spLoad(spLoad),
  .setIFlag(setIFlag)
);

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycleEn = 1'b1;
  logic        instrBoundary = 1'b0;
  logic        brkDecode = 1'b0;
  logic [15:0] pcIn = 16'h0000;
  logic [7:0]  pIn = 8'h00;
  logic [7:0]  spIn = 8'hFF;
  logic        nmiN = 1'b1;
  logic        irqN = 1'b1;
  logic [7:0]  busRData;
  logic [15:0] busAddr, pcOut;
  logic [7:0]  busWData, spOut;
  logic        busWrite, seqActive, pcLoad, spLoad, setIFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  assign busRData = busAddr[7:0] ^ 8'h5A;

  irq_entry_seq u_dut (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .instrBoundary(instrBoundary),
    .brkDecode(brkDecode), .pcIn(pcIn), .pIn(pIn), .spIn(spIn), .nmiN(nmiN),
    .irqN(irqN), .busRData(busRData), .busAddr(busAddr), .busWData(busWData),
    .busWrite(busWrite), .seqActive(seqActive), .pcOut(pcOut), .pcLoad(pcLoad),
    .spOut(spOut), .spLoad(spLoad), .setIFlag(setIFlag)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doPoll(input bit brk);
    instrBoundary = 1'b1;
    brkDecode     = brk;
    @(posedge clk); #1;
    instrBoundary = 1'b0;
    brkDecode     = 1'b0;
  endtask

  task automatic idleCheck(input string req);
    @(negedge clk);
    chk(!seqActive && !busWrite, req, {15'd0, seqActive}, 16'd0);
    @(posedge clk); #1;
  endtask

  task automatic latchNmi();
    nmiN = 1'b0;
    @(posedge clk); #1;
    nmiN = 1'b1;
  endtask

  task automatic runSeq(input logic [15:0] expRet, input logic [7:0] expP,
                        input bit expNmiVec, input logic [7:0] sp0,
                        input int dropAt, input int stallAt, input bit holdBnd,
                        input string vecReq);
    logic [15:0] vec;
    vec = expNmiVec ? 16'hFFFA : 16'hFFFE;
    for (int s = 0; s < 7; s++) begin
      if (s == dropAt) nmiN = 1'b0;
      instrBoundary = holdBnd && (s < 6);
      if (s == stallAt) begin
        cycleEn = 1'b0;
        @(negedge clk);
        chk(!busWrite && !pcLoad && seqActive, "R11 stall", {14'd0, busWrite, pcLoad}, 16'd0);
        @(posedge clk); #1;
        cycleEn = 1'b1;
      end
      @(negedge clk);
      case (s)
        0, 1: chk(seqActive && busAddr == expRet && !busWrite, "R1 dummy read", busAddr, expRet);
        2: begin
          chk(busWrite && busAddr == {8'h01, sp0}, "R2 push hi addr", busAddr, {8'h01, sp0});
          chk(busWData == expRet[15:8], "R3 push hi data", {8'd0, busWData}, {8'd0, expRet[15:8]});
        end
        3: begin
          chk(busWrite && busAddr == {8'h01, 8'(sp0 - 8'd1)}, "R2 push lo addr", busAddr,
              {8'h01, 8'(sp0 - 8'd1)});
          chk(busWData == expRet[7:0], "R3 push lo data", {8'd0, busWData}, {8'd0, expRet[7:0]});
        end
        4: begin
          chk(busWrite && busAddr == {8'h01, 8'(sp0 - 8'd2)}, "R2 push p addr", busAddr,
              {8'h01, 8'(sp0 - 8'd2)});
          chk(busWData == expP, "R4 pushed status", {8'd0, busWData}, {8'd0, expP});
        end
        5: chk(!busWrite && setIFlag && busAddr == vec, {vecReq, " vector low R5"}, busAddr, vec);
        6: begin
          chk(pcLoad && busAddr == vec + 16'd1, {vecReq, " vector high R5"}, busAddr, vec + 16'd1);
          chk(pcOut == {8'(vec[7:0] + 8'd1) ^ 8'h5A, vec[7:0] ^ 8'h5A}, "R5 pcOut", pcOut,
              {8'(vec[7:0] + 8'd1) ^ 8'h5A, vec[7:0] ^ 8'h5A});
          chk(spLoad && spOut == 8'(sp0 - 8'd3), "R2 final sp", {8'd0, spOut},
              {8'd0, 8'(sp0 - 8'd3)});
        end
        default: ;
      endcase
      @(posedge clk); #1;
    end
    instrBoundary = 1'b0;
    @(negedge clk);
    chk(!seqActive, holdBnd ? "R12 length with boundary held" : "R1 length", {15'd0, seqActive}, 16'd0);
    nmiN = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic tReset();
    @(negedge clk);
    chk(!seqActive && !busWrite && !pcLoad && !setIFlag, "R1 reset idle",
        {12'd0, seqActive, busWrite, pcLoad, setIFlag}, 16'd0);
    @(posedge clk); #1;
  endtask

  task automatic tIrqPlain();
    pcIn = 16'h1234; pIn = 8'h03; spIn = 8'hFD; irqN = 1'b0;
    doPoll(1'b0);
    runSeq(16'h1234, 8'h23, 1'b0, 8'hFD, 99, 99, 1'b0, "R6 irq");
    irqN = 1'b1;
  endtask

  task automatic tIrqMasked();
    pIn = 8'h04; irqN = 1'b0;
    doPoll(1'b0);
    idleCheck("R6 masked irq");
    irqN = 1'b1;
  endtask

  task automatic tBrk();
    pcIn = 16'h2000; pIn = 8'hC1; spIn = 8'hFF;
    doPoll(1'b1);
    runSeq(16'h2002, 8'hF1, 1'b0, 8'hFF, 99, 99, 1'b1, "R3 brk");
  endtask

  task automatic tNmi();
    pcIn = 16'h3456; pIn = 8'h14; spIn = 8'hE0;
    latchNmi();
    @(posedge clk); #1;
    doPoll(1'b0);
    runSeq(16'h3456, 8'h24, 1'b1, 8'hE0, 99, 99, 1'b0, "R6 nmi");
    doPoll(1'b0);
    idleCheck("R6 nmi serviced once");
  endtask

  task automatic tHijackBrk();
    pcIn = 16'h4000; pIn = 8'h00; spIn = 8'hF0;
    doPoll(1'b1);
    runSeq(16'h4002, 8'h30, 1'b1, 8'hF0, 4, 99, 1'b0, "R7 brk takeover");
    doPoll(1'b0);
    idleCheck("R9 brk lost");
  endtask

  task automatic tHijackIrq();
    pcIn = 16'h5000; pIn = 8'h01; spIn = 8'hC0; irqN = 1'b0;
    doPoll(1'b0);
    runSeq(16'h5000, 8'h21, 1'b1, 8'hC0, 0, 99, 1'b0, "R7 irq takeover");
    pIn = 8'h05;
    doPoll(1'b0);
    idleCheck("R10 masked after takeover");
    pIn = 8'h01;
    doPoll(1'b0);
    runSeq(16'h5000, 8'h21, 1'b0, 8'hC0, 99, 99, 1'b0, "R10 irq returns");
    irqN = 1'b1;
    doPoll(1'b0);
    idleCheck("R10 acknowledged");
  endtask

  task automatic tLateIrq();
    pcIn = 16'h6000; pIn = 8'h00; spIn = 8'hA0; irqN = 1'b0;
    doPoll(1'b0);
    runSeq(16'h6000, 8'h20, 1'b0, 8'hA0, 5, 99, 1'b0, "R8 late step5");
    irqN = 1'b1;
    idleCheck("R8 waits for boundary");
    doPoll(1'b0);
    runSeq(16'h6000, 8'h20, 1'b1, 8'hA0, 99, 99, 1'b0, "R8 deferred nmi");
  endtask

  task automatic tLateBrk();
    pcIn = 16'h7000; pIn = 8'h00; spIn = 8'h90;
    doPoll(1'b1);
    runSeq(16'h7002, 8'h30, 1'b0, 8'h90, 6, 99, 1'b0, "R8 late step6");
    doPoll(1'b0);
    runSeq(16'h7000, 8'h20, 1'b1, 8'h90, 99, 99, 1'b0, "R8 deferred nmi brk");
  endtask

  task automatic tPriority();
    pcIn = 16'h8000; pIn = 8'h00; spIn = 8'h80; irqN = 1'b0;
    latchNmi();
    doPoll(1'b1);
    runSeq(16'h8000, 8'h20, 1'b1, 8'h80, 99, 99, 1'b0, "R6 priority");
    irqN = 1'b1;
  endtask

  task automatic tStall();
    pcIn = 16'h9ABC; pIn = 8'h00; spIn = 8'h70; irqN = 1'b0;
    doPoll(1'b0);
    runSeq(16'h9ABC, 8'h20, 1'b0, 8'h70, 99, 3, 1'b0, "R11 stalled irq");
    irqN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tIrqPlain();
    tIrqMasked();
    tBrk();
    tNmi();
    tHijackBrk();
    tHijackIrq();
    tLateIrq();
    tLateBrk();
    tPriority();
    tStall();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule